// File: doc/BRIEF.md
# Atomic Memory Read-Modify-Write Unit

This unit carries out the atomic store-class instructions of a 64-bit register machine against a single-ported memory. An issue pulse hands it the 8-bit opcode, the 16-bit offset, the 32-bit immediate, and the values of three registers. The destination register holds the base address. The source register holds the operand. R0 holds the comparand. The unit forms the effective address, reads the memory word, computes the new value and writes it back. The write is skipped when a compare fails. On its one-cycle completion strobe it returns write-back values for the source register or for R0.

The operation is selected by the immediate, not the opcode. Bit 0 of the immediate is a fetch modifier that requests the old memory value. A lock output covers the whole read-to-write window, so that a shared memory port can hold off any other requester.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Only opcode 0xdb (64-bit) and 0xc3 (32-bit) are accepted: store-register class in bits [2:0] = 3, atomic mode in bits [7:5] = 6, and size in bits [4:3] of 3 or 0. Byte size (0xd3), halfword size (0xcb) and any other opcode are rejected.
- R2: The memory address is the destination register plus the sign-extended 16-bit offset. It is held stable while a request waits for its acknowledge.
- R3: Immediate bits [7:4] select the operation: 0x0 add, 0x4 or, 0x5 and, 0xa xor. The memory receives the old value combined with the source register. A 32-bit form works on bits [31:0] only, and drives mem_wide low.
- R4: With immediate bit 0 set, a simple operation returns the old memory value on src_wb_data with src_wb_en high. With bit 0 clear, no register write-back occurs.
- R5: Immediate 0xe1 (exchange) writes the source register to memory and returns the old value through the source write-back.
- R6: Immediate 0xf1 (compare-exchange) writes the source register only if memory equals R0, compared on 32 or 64 bits. In both cases it returns the old value through r0_wb_en/r0_wb_data and asserts no source write-back.
- R7: The following raise illegal on the done strobe, with no memory request and no register write-back: an opcode rejected by R1, exchange or compare-exchange without bit 0, and any immediate outside the set above, including nonzero bits [31:8] or [3:1].
- R8: mem_lock rises with the read request and stays high without a gap until the write is acknowledged, or until completion when the write is skipped.
- R9: Operands are captured on the issue cycle. issue is ignored while the unit is busy. done is a single-cycle strobe.
- R10: A 32-bit form zero-extends the returned old value and ignores memory read data bits [63:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Start an instruction (taken only when idle) |
| opcode | input | 8 | Instruction opcode |
| offset | input | 16 | Signed address offset |
| imm | input | 32 | Immediate selecting the atomic operation |
| base_val | input | 64 | Destination register value (base address) |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | R0 value (comparand) |
| busy | output | 1 | Instruction in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | 64-bit access when high, 32-bit when low |
| mem_lock | output | 1 | Hold off other memory masters |
| mem_addr | output | 64 | Memory address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with mem_ack on a read |
| mem_ack | input | 1 | Memory completes the current request |
| done | output | 1 | Completion strobe |
| illegal | output | 1 | Instruction rejected (valid with done) |
| src_wb_en | output | 1 | Write old value to source register |
| src_wb_data | output | 64 | Source register write-back value |
| r0_wb_en | output | 1 | Write old value to R0 |
| r0_wb_data | output | 64 | R0 write-back value |

## Verification
Two functions can fall in the same cycle. The first is the completion strobe of one instruction. The second is a new issue that arrives while the lock is still held from the previous read. The bench provokes this by holding issue high across a whole transaction and by changing the operand inputs after the issue cycle. It then judges the outcome by the result values and by the number of memory reads and writes seen. A second overlap is the compare inside compare-exchange, which decides in one cycle both whether a write occurs and what R0 receives. Random comparands that match the memory word about half the time cover both outcomes, at both widths, and against a memory that acknowledges with random delay.

// File: rtl/atomic_pkg.sv
package atomic_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_CALC, ST_WRITE, ST_DONE} state_t;
  typedef enum logic [2:0] {OP_ADD, OP_OR, OP_AND, OP_XOR, OP_XCHG, OP_CMPX} aop_t;

  typedef struct packed {
    logic legal;
    logic wide;
    logic fetch;
    aop_t op;
  } dec_t;

  localparam logic [2:0] CLASS_STX  = 3'h3;
  localparam logic [2:0] MODE_ATOM  = 3'h6;
  localparam logic [1:0] SIZE_WORD  = 2'b00;
  localparam logic [1:0] SIZE_DWORD = 2'b11;
endpackage

// File: rtl/atomic_decode.sv
module atomic_decode
  import atomic_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [7:0]       opcode,
  input  logic [IMM_W-1:0] imm,
  output dec_t             dec
);
  logic class_ok, size_ok, imm_clean, op_ok;

  always_comb begin
    class_ok  = (opcode[2:0] == CLASS_STX) && (opcode[7:5] == MODE_ATOM);
    size_ok   = (opcode[4:3] == SIZE_WORD) || (opcode[4:3] == SIZE_DWORD);
    imm_clean = (imm[IMM_W-1:8] == '0) && (imm[3:1] == 3'b000);
    dec.wide  = (opcode[4:3] == SIZE_DWORD);
    dec.fetch = imm[0];
    op_ok     = 1'b1;
    dec.op    = OP_ADD;
    unique case (imm[7:4])
      4'h0: dec.op = OP_ADD;
      4'h4: dec.op = OP_OR;
      4'h5: dec.op = OP_AND;
      4'ha: dec.op = OP_XOR;
      4'he: begin dec.op = OP_XCHG; op_ok = imm[0]; end
      4'hf: begin dec.op = OP_CMPX; op_ok = imm[0]; end
      default: op_ok = 1'b0;
    endcase
    dec.legal = class_ok && size_ok && imm_clean && op_ok;
  end
endmodule

// File: rtl/atomic_alu.sv
module atomic_alu
  import atomic_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  aop_t            op,
  input  logic            wide,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] operand,
  input  logic [XLEN-1:0] comparand,
  output logic [XLEN-1:0] new_val,
  output logic            do_write
);
  localparam int HALF = XLEN / 2;
  logic [XLEN-1:0] mask, raw;
  logic            match;

  always_comb begin
    mask = wide ? '1 : {{HALF{1'b0}}, {HALF{1'b1}}};
    unique case (op)
      OP_ADD:  raw = old_val + operand;
      OP_OR:   raw = old_val | operand;
      OP_AND:  raw = old_val & operand;
      OP_XOR:  raw = old_val ^ operand;
      default: raw = operand;
    endcase
    new_val  = raw & mask;
    match    = ((old_val ^ comparand) & mask) == '0;
    do_write = (op != OP_CMPX) || match;
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int OFF_W = 16,
  parameter int IMM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [7:0]       opcode,
  input  logic [OFF_W-1:0] offset,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  src_val,
  input  logic [XLEN-1:0]  r0_val,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_wide,
  output logic             mem_lock,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata,
  input  logic             mem_ack,
  output logic             done,
  output logic             illegal,
  output logic             src_wb_en,
  output logic [XLEN-1:0]  src_wb_data,
  output logic             r0_wb_en,
  output logic [XLEN-1:0]  r0_wb_data
);
  localparam int HALF = XLEN / 2;

  state_t          state_q, state_d;
  dec_t            dec_in, dec_q;
  logic [XLEN-1:0] addr_q, src_q, r0_q, old_q, eff_addr, rd_masked;
  logic [XLEN-1:0] alu_new;
  logic            alu_wr, accept, capture_old;

  atomic_decode #(.IMM_W(IMM_W)) dec_i (.opcode(opcode), .imm(imm), .dec(dec_in));

  atomic_alu #(.XLEN(XLEN)) alu_i (
    .op(dec_q.op), .wide(dec_q.wide), .old_val(old_q), .operand(src_q),
    .comparand(r0_q), .new_val(alu_new), .do_write(alu_wr)
  );

  assign eff_addr    = base_val + {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
  assign accept      = issue && (state_q == ST_IDLE);
  assign capture_old = (state_q == ST_READ) && mem_ack;
  assign rd_masked   = dec_q.wide ? mem_rdata : {{HALF{1'b0}}, mem_rdata[HALF-1:0]};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (issue) state_d = dec_in.legal ? ST_READ : ST_DONE;
      ST_READ:  if (mem_ack) state_d = ST_CALC;
      ST_CALC:  state_d = alu_wr ? ST_WRITE : ST_DONE;
      ST_WRITE: if (mem_ack) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '0;
      addr_q <= '0;
      src_q  <= '0;
      r0_q   <= '0;
    end else if (accept) begin
      dec_q  <= dec_in;
      addr_q <= eff_addr;
      src_q  <= src_val;
      r0_q   <= r0_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           old_q <= '0;
    else if (capture_old) old_q <= rd_masked;
  end

  always_comb begin
    busy        = (state_q != ST_IDLE);
    mem_req     = (state_q == ST_READ) || (state_q == ST_WRITE);
    mem_we      = (state_q == ST_WRITE);
    mem_lock    = mem_req || (state_q == ST_CALC);
    mem_wide    = dec_q.wide;
    mem_addr    = addr_q;
    mem_wdata   = alu_new;
    done        = (state_q == ST_DONE);
    illegal     = done && !dec_q.legal;
    src_wb_en   = done && dec_q.legal && dec_q.fetch && (dec_q.op != OP_CMPX);
    r0_wb_en    = done && dec_q.legal && (dec_q.op == OP_CMPX);
    src_wb_data = old_q;
    r0_wb_data  = old_q;
  end
endmodule

module atomic_rmw_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_lock,
  input logic            mem_ack,
  input logic [XLEN-1:0] mem_addr,
  input logic            done,
  input logic            illegal,
  input logic            src_wb_en,
  input logic            r0_wb_en
);
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr));
  a_r8_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);
  a_r8_release_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> done);
  a_r8_write_follows_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req && mem_we) |-> $past(mem_lock));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done && !src_wb_en && !r0_wb_en && !mem_req);
  a_r6_single_wb: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_wb_en && r0_wb_en));
  a_r4_wb_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (src_wb_en || r0_wb_en) |-> done);
endmodule

bind atomic_rmw_unit atomic_rmw_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_lock(mem_lock), .mem_ack(mem_ack), .mem_addr(mem_addr), .done(done),
  .illegal(illegal), .src_wb_en(src_wb_en), .r0_wb_en(r0_wb_en)
);

// File: tb/atomic_rmw_unit_tb_top.sv
module atomic_rmw_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, issue;
  logic [7:0]  opcode;
  logic [15:0] offset;
  logic [31:0] imm;
  logic [63:0] base_val, src_val, r0_val;
  logic        busy, mem_req, mem_we, mem_wide, mem_lock;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack, done, illegal, src_wb_en, r0_wb_en;
  logic [63:0] src_wb_data, r0_wb_data;

  atomic_rmw_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .offset(offset),
    .imm(imm), .base_val(base_val), .src_val(src_val), .r0_val(r0_val),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .done(done), .illegal(illegal),
    .src_wb_en(src_wb_en), .src_wb_data(src_wb_data), .r0_wb_en(r0_wb_en),
    .r0_wb_data(r0_wb_data)
  );

  logic [63:0] mem [16];
  int n_chk, n_fail, n_rd, n_wr;
  logic [63:0] last_addr;
  logic in_txn, lock_gap;
  bit   finished;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder, random acknowledge delay; word reads carry garbage in [63:32]
  initial begin
    mem_ack = 1'b0; mem_rdata = '0; in_txn = 1'b0; lock_gap = 1'b0;
    forever begin
      @(negedge clk);
      if (done) in_txn = 1'b0;
      else if (in_txn && !mem_lock) lock_gap = 1'b1;
      if (mem_req && !mem_ack && ($urandom % 3 != 0)) begin
        automatic int i = int'(mem_addr[6:3]);
        mem_ack = 1'b1;
        last_addr = mem_addr;
        if (mem_we) begin
          n_wr++;
          in_txn = 1'b0;
          if (mem_wide) mem[i] = mem_wdata;
          else if (mem_addr[2]) mem[i][63:32] = mem_wdata[31:0];
          else mem[i][31:0] = mem_wdata[31:0];
        end else begin
          n_rd++;
          in_txn = 1'b1;
          mem_rdata = mem_wide ? mem[i] :
                      {32'hbad0_f00d, mem_addr[2] ? mem[i][63:32] : mem[i][31:0]};
        end
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  function automatic bit legal_of(input logic [7:0] opc, input logic [31:0] im);
    bit ok;
    ok = (opc == 8'hdb || opc == 8'hc3) && im[31:8] == 0 && im[3:1] == 0;
    case (im[7:4])
      4'h0, 4'h4, 4'h5, 4'ha: ;
      4'he, 4'hf: ok = ok && im[0];
      default: ok = 0;
    endcase
    return ok;
  endfunction

  task automatic run_op(input logic [7:0] opc, input logic [15:0] off,
                        input logic [31:0] im, input logic [63:0] base,
                        input logic [63:0] src, input logic [63:0] r0,
                        input bit hold_issue);
    logic [63:0] addr, oldv, a, newv, exp_word, word_before;
    bit wide, lg, wr, fetch;
    int i, cyc;
    addr = base + {{48{off[15]}}, off};
    i = int'(addr[6:3]);
    wide = (opc == 8'hdb);
    lg = legal_of(opc, im);
    fetch = im[0];
    word_before = mem[i];
    oldv = wide ? word_before : {32'h0, addr[2] ? word_before[63:32] : word_before[31:0]};
    a = wide ? src : {32'h0, src[31:0]};
    wr = 1;
    case (im[7:4])
      4'h0: newv = oldv + a;
      4'h4: newv = oldv | a;
      4'h5: newv = oldv & a;
      4'ha: newv = oldv ^ a;
      4'hf: begin newv = a; wr = wide ? (oldv == r0) : (oldv[31:0] == r0[31:0]); end
      default: newv = a;
    endcase
    if (!wide) newv[63:32] = 32'h0;
    exp_word = word_before;
    if (lg && wr) begin
      if (wide) exp_word = newv;
      else if (addr[2]) exp_word[63:32] = newv[31:0];
      else exp_word[31:0] = newv[31:0];
    end
    n_rd = 0; n_wr = 0; lock_gap = 1'b0;
    @(negedge clk);
    issue = 1; opcode = opc; offset = off; imm = im;
    base_val = base; src_val = src; r0_val = r0;
    @(negedge clk);
    if (!hold_issue) issue = 0;
    // scramble operands after capture (R9)
    opcode = 8'hdb; offset = 16'h0008; imm = 32'h0000_00f1;
    base_val = ~base; src_val = ~src; r0_val = ~r0;
    cyc = 0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    issue = 0;
    chk(done, "R9 done reached", 64'(done), 64'd1);
    chk(illegal == !lg, "R7 illegal flag", 64'(illegal), 64'(!lg));
    if (lg) begin
      chk(last_addr == addr, "R2 address", last_addr, addr);
      chk(n_rd == 1 && n_wr == int'(wr), "R9 read/write count", 64'(n_rd * 16 + n_wr),
          64'(16 + int'(wr)));
      chk(mem[i] == exp_word, wr ? "R3 R5 R6 memory word" : "R6 no write on mismatch",
          mem[i], exp_word);
      chk(!lock_gap, "R8 lock held", 64'(lock_gap), 64'd0);
      if (im[7:4] == 4'hf) begin
        chk(r0_wb_en && !src_wb_en && r0_wb_data == oldv, "R6 R10 r0 writeback",
            r0_wb_data, oldv);
      end else begin
        chk(src_wb_en == fetch && !r0_wb_en, "R4 writeback enable",
            64'(src_wb_en), 64'(fetch));
        if (fetch) chk(src_wb_data == oldv, "R4 R5 R10 old value", src_wb_data, oldv);
      end
    end else begin
      chk(n_rd == 0 && n_wr == 0 && mem[i] == word_before, "R7 R1 no memory access",
          64'(n_rd + n_wr), 64'd0);
      chk(!src_wb_en && !r0_wb_en, "R7 no writeback", 64'(src_wb_en | r0_wb_en), 64'd0);
    end
    @(negedge clk);
    chk(!done && !busy, "R9 done single pulse", 64'(done), 64'd0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
          n_chk++; n_fail++;
          $display("FAIL R9 watchdog expired actual=hung expected=finish");
          $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    void'($urandom(32'd1234));
    n_chk = 0; n_fail = 0; finished = 0;
    issue = 0; opcode = 0; offset = 0; imm = 0; base_val = 0; src_val = 0; r0_val = 0;
    for (int k = 0; k < 16; k++) mem[k] = {$urandom, $urandom};
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !mem_lock && !done, "R9 reset state",
        {60'h0, busy, mem_req, mem_lock, done}, 64'h0);
    rst_n = 1;
    // directed corners
    run_op(8'hdb, 16'h0010, 32'h01, 64'h1000, 64'h5, 0, 0);           // R3 add fetch
    run_op(8'hc3, 16'hfffc, 32'h00, 64'h1020, 64'hffff_ffff, 0, 0);   // R2 negative offset, R3 word add
    run_op(8'hc3, 16'h0004, 32'h41, 64'h1000, 64'h0f0f, 0, 0);        // R3 or, upper half, R10
    run_op(8'hdb, 16'h0000, 32'h51, 64'h1008, 64'hff00, 0, 0);        // R3 and
    run_op(8'hdb, 16'h0000, 32'ha0, 64'h1008, 64'hffff, 0, 0);        // R3 xor no fetch R4
    run_op(8'hdb, 16'h0018, 32'he1, 64'h1000, 64'h1234, 0, 0);        // R5 exchange
    run_op(8'hdb, 16'h0018, 32'hf1, 64'h1000, 64'hbeef, 64'h1234, 0); // R6 match
    run_op(8'hdb, 16'h0018, 32'hf1, 64'h1000, 64'h7777, 64'h1, 0);    // R6 mismatch
    run_op(8'hc3, 16'h0020, 32'hf1, 64'h1000, 64'h9, {32'hffff_ffff, mem[4][31:0]}, 0); // R6 R10 word compare
    run_op(8'hd3, 16'h0, 32'h01, 64'h1000, 1, 0, 0);                  // R1 byte rejected
    run_op(8'hcb, 16'h0, 32'h01, 64'h1000, 1, 0, 0);                  // R1 half rejected
    run_op(8'hc2, 16'h0, 32'h00, 64'h1000, 1, 0, 0);                  // R1 wrong class
    run_op(8'hdb, 16'h0, 32'he0, 64'h1000, 1, 0, 0);                  // R7 xchg no fetch
    run_op(8'hdb, 16'h0, 32'hf0, 64'h1000, 1, 0, 0);                  // R7 cmpxchg no fetch
    run_op(8'hdb, 16'h0, 32'h0000_0101, 64'h1000, 1, 0, 0);           // R7 stray high bit
    run_op(8'hdb, 16'h0, 32'h10, 64'h1000, 1, 0, 0);                  // R7 unknown op
    run_op(8'hdb, 16'h0008, 32'h01, 64'h1000, 64'h3, 0, 1);           // R9 issue held while busy
    // constrained random
    for (int n = 0; n < 400; n++) begin
      automatic logic [31:0] imms [14] = '{32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51,
        32'ha0, 32'ha1, 32'he1, 32'hf1, 32'hf1, 32'he0, 32'h31, 32'h08};
      automatic logic [7:0]  opcs [6]  = '{8'hdb, 8'hc3, 8'hdb, 8'hc3, 8'hd3, 8'hcb};
      automatic logic [7:0]  o  = opcs[$urandom % 6];
      automatic logic [31:0] im = imms[$urandom % 14];
      automatic logic [15:0] off = 16'(($urandom % 64) * 4) - 16'd128;
      automatic logic [63:0] b = {$urandom, $urandom} & ~64'h7;
      automatic logic [63:0] ad = b + {{48{off[15]}}, off};
      automatic logic [63:0] r0v = {$urandom, $urandom};
      if (o == 8'hdb) begin off[2] = 1'b0; ad = b + {{48{off[15]}}, off}; end
      if ($urandom % 2 == 0)
        r0v = (o == 8'hdb) ? mem[ad[6:3]] :
              {32'($urandom), ad[2] ? mem[ad[6:3]][63:32] : mem[ad[6:3]][31:0]};
      run_op(o, off, im, b, {$urandom, $urandom}, r0v, ($urandom % 8 == 0));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule